// File: doc/BRIEF.md
# Packed 128-bit SIMD Integer Unit

This execution unit applies a single integer operation to every lane of a 128-bit operand pair at once. A two-bit granularity field splits each operand into sixteen 8-bit, eight 16-bit or four 32-bit lanes. The available operations are:

- wrapping add and subtract
- signed minimum and maximum
- logical left shift
- logical and arithmetic right shifts
- four bitwise functions
- per-lane count of leading zeros
- a funnel extract that takes a 128-bit window out of the 256-bit joint of both sources

The lane datapath is two 64-bit halves side by side. Each half holds one lane bank for each granularity. The funnel extract spans the full width.

An issuing stage presents both sources, an opcode, the granularity, a shift amount and a valid strobe. The result and its valid flag come out of a register one clock later. The unit never stalls.

Top module: `simd_int_unit`

## Requirements
- R1: `lsz_i` selects the lane granularity: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 or 3 gives 32-bit lanes. Every lane computes independently and no carry, borrow or shifted bit crosses a lane boundary.
- R2: Opcode 0 adds lane-wise and opcode 1 subtracts (a minus b) lane-wise. Both wrap modulo 2 to the power of the lane width.
- R3: Opcode 2 returns the lane-wise minimum and opcode 3 the lane-wise maximum. Both compare the lanes as two's-complement signed values.
- R4: Opcode 4 shifts left logically, opcode 5 shifts right logically and opcode 6 shifts right arithmetically. Every lane shifts by `shamt_i` modulo the lane width.
- R5: Opcodes 7, 8, 9 and 10 return the bitwise AND, OR, XOR and NOR of the sources.
- R6: Opcode 11 returns, in each lane of `src_a_i`, the number of zero bits above the most significant one. A lane that is all zero returns the lane width.
- R7: Opcode 12 returns bits `shamt_i`+127 down to `shamt_i` of the 256-bit value {`src_b_i`, `src_a_i`}. A shift amount of 0 returns `src_a_i` unchanged. This operation ignores `lsz_i`.
- R8: The result of an operation accepted with `valid_i` high appears on `result_o` after the next rising clock edge. `valid_o` is the value `valid_i` had at that edge.
- R9: `result_o` keeps its value across any edge at which `valid_i` is low.
- R10: While `rst_n` is low at a rising edge, `valid_o` and `result_o` are cleared to zero.
- R11: Opcodes 13, 14 and 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| lsz_i | input | 2 | Lane granularity select |
| shamt_i | input | 7 | Shift amount for the lane shifts and the funnel extract |
| src_a_i | input | 128 | First source; the low half of the funnel joint |
| src_b_i | input | 128 | Second source; the high half of the funnel joint |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Registered result |

## Verification
Every result is due exactly one rising edge after the edge that samples its `valid_i`. The bench drives each operation on a falling edge and reads `result_o` and `valid_o` on the next falling edge, half a period after the capturing edge. One further falling edge later, with `valid_i` low, it confirms that `valid_o` has dropped and that `result_o` has kept its value. Reset behaviour is checked at the same falling-edge points, both when the run starts and when reset is asserted in the middle of held data.

// File: rtl/simd_pkg.sv
// Shared types for the packed SIMD integer unit.
// Assumes a 4-bit opcode field; codes above OP_FUNNEL are unused.
package simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_MIN    = 4'd2,
        OP_MAX    = 4'd3,
        OP_SLL    = 4'd4,
        OP_SRL    = 4'd5,
        OP_SRA    = 4'd6,
        OP_AND    = 4'd7,
        OP_OR     = 4'd8,
        OP_XOR    = 4'd9,
        OP_NOR    = 4'd10,
        OP_CLZ    = 4'd11,
        OP_FUNNEL = 4'd12
    } op_e;

    localparam int NUM_GRAN = 3;   // 8-, 16- and 32-bit lanes
    localparam int MIN_LANE = 8;

endpackage

// File: rtl/simd_lane.sv
// One lane of width W. Evaluates every lane-wise opcode combinationally.
// Assumes that W is a power of two and that SH_W is at least log2(W).
// Opcodes this lane does not handle yield zero.
module simd_lane
    import simd_pkg::*;
#(
    parameter int W    = 8,
    parameter int SH_W = 7
) (
    input  op_e             op_i,
    input  logic [SH_W-1:0] shamt_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o
);
    localparam int CW = $clog2(W) + 1;

    logic [SH_W-1:0] sh;
    logic [CW-1:0]   lz;
    logic [W-1:0]    res;

    // Evaluates the selected operation and checks its bounds in the same pass.
    always_comb begin : lane_eval
        sh = shamt_i % SH_W'(W);
        lz = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a_i[i]) lz = CW'(W - 1 - i);
        end
        case (op_i)
            OP_ADD:  res = a_i + b_i;
            OP_SUB:  res = a_i - b_i;
            OP_MIN:  res = ($signed(a_i) < $signed(b_i)) ? a_i : b_i;
            OP_MAX:  res = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
            OP_SLL:  res = a_i << sh;
            OP_SRL:  res = a_i >> sh;
            OP_SRA:  res = $unsigned($signed(a_i) >>> sh);
            OP_AND:  res = a_i & b_i;
            OP_OR:   res = a_i | b_i;
            OP_XOR:  res = a_i ^ b_i;
            OP_NOR:  res = ~(a_i | b_i);
            OP_CLZ:  res = W'(lz);
            default: res = '0;
        endcase
        res_o = res;
        // R6
        if (op_i == OP_CLZ && a_i == '0) begin
            clz_zero_chk: assert (res == W'(W));
        end
        // R3
        if (op_i == OP_MIN) begin
            min_bound_chk: assert ($signed(res) <= $signed(a_i) && $signed(res) <= $signed(b_i));
        end
        // R3
        if (op_i == OP_MAX) begin
            max_bound_chk: assert ($signed(res) >= $signed(a_i) && $signed(res) >= $signed(b_i));
        end
    end
endmodule

// File: rtl/simd_half.sv
// One 64-bit half of the lane datapath. Holds a lane bank for each
// granularity and selects one bank by lsz_i (0: 8, 1: 16, 2 or 3: 32 bits).
// Assumes that HALF_W is a multiple of the widest lane.
module simd_half
    import simd_pkg::*;
#(
    parameter int HALF_W = 64,
    parameter int SH_W   = 7
) (
    input  op_e               op_i,
    input  logic [1:0]        lsz_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [HALF_W-1:0] a_i,
    input  logic [HALF_W-1:0] b_i,
    output logic [HALF_W-1:0] res_o
);
    for (genvar g = 0; g < NUM_GRAN; g++) begin : bank
        localparam int W = MIN_LANE << g;
        localparam int N = HALF_W / W;
        logic [HALF_W-1:0] r;
        for (genvar l = 0; l < N; l++) begin : lane
            simd_lane #(.W(W), .SH_W(SH_W)) u_lane (
                .op_i    (op_i),
                .shamt_i (shamt_i),
                .a_i     (a_i[l*W +: W]),
                .b_i     (b_i[l*W +: W]),
                .res_o   (r[l*W +: W])
            );
        end
    end

    // Picks the bank that matches the requested lane granularity.
    always_comb begin : gran_sel
        case (lsz_i)
            2'b00:   res_o = bank[0].r;
            2'b01:   res_o = bank[1].r;
            default: res_o = bank[2].r;
        endcase
    end
endmodule

// File: rtl/simd_funnel.sv
// Funnel extract: joins hi_i above lo_i and returns DW bits starting at
// bit shamt_i. Assumes shamt_i is narrower than the joint, so 0..DW-1.
module simd_funnel #(
    parameter int DW   = 128,
    parameter int SH_W = 7
) (
    input  logic [SH_W-1:0] shamt_i,
    input  logic [DW-1:0]   lo_i,
    input  logic [DW-1:0]   hi_i,
    output logic [DW-1:0]   res_o
);
    logic [2*DW-1:0] joint;

    // Shifts the joint right and keeps the low window.
    always_comb begin : window
        joint = {hi_i, lo_i} >> shamt_i;
        res_o = joint[DW-1:0];
        // R7
        if (shamt_i == '0) begin
            funnel_zero_chk: assert (joint[DW-1:0] == lo_i);
        end
    end
endmodule

// File: rtl/simd_int_unit.sv
// Packed SIMD integer unit. The lane datapath is built from HALF_W halves,
// and the funnel extract spans the full width. The result and its valid
// flag are registered, giving one cycle of latency with no stalls.
// Assumes that DATA_W is a multiple of HALF_W. The reset is synchronous
// and active low.
module simd_int_unit
    import simd_pkg::*;
#(
    parameter  int DATA_W = 128,
    parameter  int HALF_W = 64,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        lsz_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int HALVES = DATA_W / HALF_W;

    op_e               op;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] fun_res;
    logic [DATA_W-1:0] next_res;

    assign op = op_e'(op_i);

    for (genvar h = 0; h < HALVES; h++) begin : half
        simd_half #(.HALF_W(HALF_W), .SH_W(SH_W)) u_half (
            .op_i    (op),
            .lsz_i   (lsz_i),
            .shamt_i (shamt_i),
            .a_i     (src_a_i[h*HALF_W +: HALF_W]),
            .b_i     (src_b_i[h*HALF_W +: HALF_W]),
            .res_o   (lane_res[h*HALF_W +: HALF_W])
        );
    end

    simd_funnel #(.DW(DATA_W), .SH_W(SH_W)) u_funnel (
        .shamt_i (shamt_i),
        .lo_i    (src_a_i),
        .hi_i    (src_b_i),
        .res_o   (fun_res)
    );

    // Chooses between the funnel window and the lane results.
    always_comb begin : res_sel
        next_res = (op == OP_FUNNEL) ? fun_res : lane_res;
    end

    // Output register: captures on valid and holds otherwise.
    always_ff @(posedge clk) begin : out_reg
        if (!rst_n) begin
            valid_o  <= 1'b0;
            result_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) result_o <= next_res;
        end
    end

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R8
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && result_o == '0));
    // R11
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i > 4'd12) |=> (result_o == '0));
endmodule

// File: tb/simd_int_unit_test.sv
`timescale 1ns/1ps
module simd_int_unit_test;
    localparam int NV = 25;
    // Entry layout: req[400:397] op[396:393] lsz[392:391] sh[390:384]
    //               a[383:256] b[255:128] expected[127:0]
    localparam logic [400:0] VEC [NV] = '{
        // R2 add, 8-bit lanes: each FF+01 wraps to 00 with no carry out
        {4'd2, 4'd0, 2'd0, 7'd0, {16{8'hFF}}, {16{8'h01}}, {16{8'h00}}},
        // R2 add, 16-bit lanes
        {4'd2, 4'd0, 2'd1, 7'd0, {16{8'hFF}}, {16{8'h01}}, {8{16'h0100}}},
        // R2 add, 32-bit lanes
        {4'd2, 4'd0, 2'd2, 7'd0, {16{8'hFF}}, {16{8'h01}}, {4{32'h01010100}}},
        // R2 subtract, 8-bit lanes
        {4'd2, 4'd1, 2'd0, 7'd0, {16{8'h00}}, {16{8'h01}}, {16{8'hFF}}},
        // R2 subtract, 32-bit lanes
        {4'd2, 4'd1, 2'd2, 7'd0, {16{8'h00}}, {16{8'h01}}, {4{32'hFEFEFEFF}}},
        // R3 signed min, 8-bit lanes
        {4'd3, 4'd2, 2'd0, 7'd0, {16{8'h80}}, {16{8'h7F}}, {16{8'h80}}},
        // R3 signed max, 8-bit lanes
        {4'd3, 4'd3, 2'd0, 7'd0, {16{8'h80}}, {16{8'h7F}}, {16{8'h7F}}},
        // R3 signed max, 16-bit lanes
        {4'd3, 4'd3, 2'd1, 7'd0, {8{16'h8000}}, {8{16'h0001}}, {8{16'h0001}}},
        // R4 left shift, 8-bit lanes, amount 9 taken as 1
        {4'd4, 4'd4, 2'd0, 7'd9, {16{8'h81}}, {16{8'h00}}, {16{8'h02}}},
        // R4 logical right shift, 16-bit lanes, by 4
        {4'd4, 4'd5, 2'd1, 7'd4, {8{16'h8421}}, {8{16'h0000}}, {8{16'h0842}}},
        // R4 arithmetic right shift, 16-bit lanes, by 4
        {4'd4, 4'd6, 2'd1, 7'd4, {8{16'h8421}}, {8{16'h0000}}, {8{16'hF842}}},
        // R4 arithmetic right shift, 32-bit lanes, amount 33 taken as 1
        {4'd4, 4'd6, 2'd2, 7'd33, {4{32'h80000000}}, {4{32'h0}}, {4{32'hC0000000}}},
        // R5 AND
        {4'd5, 4'd7, 2'd2, 7'd0, {4{32'hF0F0FF00}}, {4{32'hFF00F0F0}}, {4{32'hF000F000}}},
        // R5 OR
        {4'd5, 4'd8, 2'd2, 7'd0, {4{32'hF0F0FF00}}, {4{32'hFF00F0F0}}, {4{32'hFFF0FFF0}}},
        // R5 XOR
        {4'd5, 4'd9, 2'd2, 7'd0, {4{32'hF0F0FF00}}, {4{32'hFF00F0F0}}, {4{32'h0FF00FF0}}},
        // R5 NOR
        {4'd5, 4'd10, 2'd2, 7'd0, {4{32'hF0F0FF00}}, {4{32'hFF00F0F0}}, {4{32'h000F000F}}},
        // R6 leading zeros, 8-bit lanes
        {4'd6, 4'd11, 2'd0, 7'd0, {8{16'h0180}}, {8{16'h0000}}, {8{16'h0700}}},
        // R6 leading zeros of all-zero 16-bit lanes equals 16
        {4'd6, 4'd11, 2'd1, 7'd0, {8{16'h0000}}, {8{16'h0000}}, {8{16'h0010}}},
        // R6 leading zeros, 32-bit lanes
        {4'd6, 4'd11, 2'd2, 7'd0, {4{32'h00010000}}, {4{32'h0}}, {4{32'h0000000F}}},
        // R7 funnel by 0 returns the low source
        {4'd7, 4'd12, 2'd0, 7'd0, 128'h0123456789ABCDEF_FEDCBA9876543210, {8{16'h5555}},
         128'h0123456789ABCDEF_FEDCBA9876543210},
        // R7 funnel by 4
        {4'd7, 4'd12, 2'd1, 7'd4, 128'h0123456789ABCDEF_FEDCBA9876543210, {8{16'h5555}},
         128'h50123456789ABCDE_FFEDCBA987654321},
        // R7 funnel by 64
        {4'd7, 4'd12, 2'd2, 7'd64, 128'h0123456789ABCDEF_FEDCBA9876543210, {8{16'h5555}},
         128'h5555555555555555_0123456789ABCDEF},
        // R7 funnel by 127
        {4'd7, 4'd12, 2'd0, 7'd127, 128'h0123456789ABCDEF_FEDCBA9876543210, {8{16'h5555}},
         {8{16'hAAAA}}},
        // R11 unused opcode 14 gives zero
        {4'd11, 4'd14, 2'd2, 7'd3, {16{8'hFF}}, {16{8'h01}}, 128'h0},
        // R1 granularity code 3 behaves as 32-bit lanes
        {4'd1, 4'd0, 2'd3, 7'd0, {16{8'hFF}}, {16{8'h01}}, {4{32'h01010100}}}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [3:0]   op_i = '0;
    logic [1:0]   lsz_i = '0;
    logic [6:0]   shamt_i = '0;
    logic [127:0] src_a_i = '0;
    logic [127:0] src_b_i = '0;
    logic         valid_o;
    logic [127:0] result_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    simd_int_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .op_i     (op_i),
        .lsz_i    (lsz_i),
        .shamt_i  (shamt_i),
        .src_a_i  (src_a_i),
        .src_b_i  (src_b_i),
        .valid_o  (valid_o),
        .result_o (result_o)
    );

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drives one operation on a falling edge; the result is read one falling edge later.
    task automatic issue(input logic [3:0] op, input logic [1:0] lsz, input logic [6:0] sh,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; lsz_i = lsz; shamt_i = sh; src_a_i = a; src_b_i = b;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {127'd0, valid_o}, 128'd0);
        check("R10", result_o, 128'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][396:393], VEC[i][392:391], VEC[i][390:384],
                  VEC[i][383:256], VEC[i][255:128]);
            check($sformatf("R%0d vec %0d", VEC[i][400:397], i), result_o, VEC[i][127:0]);
            check("R8 valid", {127'd0, valid_o}, 128'd1);
            held = result_o;
            // R9: one idle edge, then the result must be held and valid low
            src_a_i = ~src_a_i; op_i = 4'd1;
            @(negedge clk);
            check("R9 hold", result_o, held);
            check("R8 idle", {127'd0, valid_o}, 128'd0);
        end

        // R8 back-to-back operations, each due one edge after issue
        @(negedge clk);
        valid_i = 1'b1; op_i = 4'd0; lsz_i = 2'd0; src_a_i = {16{8'h01}}; src_b_i = {16{8'h01}};
        @(negedge clk);
        check("R8 first", result_o, {16{8'h02}});
        op_i = 4'd9; src_a_i = {16{8'hFF}}; src_b_i = {16{8'h0F}};
        @(negedge clk);
        valid_i = 1'b0;
        check("R8 second", result_o, {16{8'hF0}});
        check("R8 valid", {127'd0, valid_o}, 128'd1);

        // R10 reset in the middle of held data clears both outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid", result_o, 128'd0);
        check("R10 mid", {127'd0, valid_o}, 128'd0);
        rst_n = 1'b1;

        // R1 lane independence: only the lane holding FF wraps, its neighbour sees no carry
        issue(4'd0, 2'd1, 7'd0, {{120{1'b0}}, 8'hFF}, {{120{1'b0}}, 8'h01});
        check("R1 carry", result_o, {{112{1'b0}}, 16'h0100});
        issue(4'd0, 2'd0, 7'd0, {{120{1'b0}}, 8'hFF}, {{120{1'b0}}, 8'h01});
        check("R1 carry", result_o, 128'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule